// File: doc/BRIEF.md
# GPIO Expander Register Core

This block is the register file and pin-control logic of a 24-pin general-purpose I/O expander. A host reaches it through a byte-wide register port (address, write data, write strobe, read strobe, registered read data) that stands in for a serial bus target. Through that port the host selects, pin by pin, whether a pin drives or listens, whether a driving pin pushes and pulls or only sinks, and whether a listening pin gets a pull-up, a pull-down or no bias. Output levels are never written directly. One bank of addresses sets latch bits and another clears them, so a single pin can change without a read-modify-write.

Pins 0 to 15 form the main group and pins 16 to 23 the extra group. Each per-pin register kind occupies three consecutive byte addresses, and pin n is found in byte n/8 at bit n%8. A system-control byte enables the whole pin function and, separately, the extra group. It also carries a software reset that clears every register. The device then stays deaf for a boot window of a parameterised number of cycles. An identification byte reports the complement of the shifted bus address, which depends on one address-select input.

Top module: `gpx_regcore`

## Requirements
- R1: After the reset input is released, every control register and the output latch are zero, all pin_oe, pin_out, pin_pp, pin_pu and pin_pd bits are 0, and the device accepts accesses at once.
- R2: A read of address 0x00 returns the complement of {6'b100001, addr_sel, 1'b0}: 0x7B when addr_sel is 0 and 0x79 when it is 1. Addresses 0x01 and 0x02 return the fixed version bytes FW_HI and FW_LO.
- R3: Direction (0x60-0x62), type (0x64-0x66) and pull (0x68-0x6A) read back the byte last written. Pin n sits in byte base+n/8 at bit n%8. bus_rdata updates on the clock edge that samples bus_rd and holds until the next read.
- R4: A write to the set bank (0x6C-0x6E) sets the latch bits where the data is 1 and leaves the others. Reads of the set bank return the latch.
- R5: A write to the clear bank (0x70-0x72) clears the latch bits where the data is 1 and leaves the others. Reads of the clear bank return the latch.
- R6: An enabled pin whose direction bit is 1 drives: pin_oe=1, pin_out equals its latch bit, and pin_pp equals its type bit (1 push-pull, 0 open-drain).
- R7: An enabled pin whose direction bit is 0 has pin_oe=0. With type 0 it has no bias. With type 1, pull 1 gives pin_pu=1 and pull 0 gives pin_pd=1. pin_pu and pin_pd are never both 1.
- R8: The state bytes (0x10-0x12) return the latch bit for driving pins and the input level after a two-flop synchroniser for the other pins. Writes there change nothing.
- R9: System control at 0x40 stores bit 0 (pin enable) and bit 3 (extra-group enable) and reads back only those bits. With bit 0 at 0, every pin is an unbiased input.
- R10: Pins 16-23 are enabled only while both bit 0 and bit 3 of system control are 1. Otherwise they are unbiased inputs.
- R11: Writing 0x40 with bit 7 set clears every register, including system control, so bit 7 never reads back as 1.
- R12: For BOOT_CYCLES clock edges after a software reset, reads return 0x00 and writes are ignored.
- R13: Reads of unmapped addresses return 0x00. Writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Bus address select, folded into the identification byte |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Raw input levels of the pins |
| pin_out | output | 24 | Output level for each driving pin |
| pin_oe | output | 24 | Output enable for each pin |
| pin_pp | output | 24 | 1 = push-pull, 0 = open-drain, for driving pins |
| pin_pu | output | 24 | Pull-up request |
| pin_pd | output | 24 | Pull-down request |

## Verification
The hardest state to reach is the boot window after a software reset. The registers must already hold non-zero contents, and accesses must be attempted while the window is still open. The bench first loads direction, type, pull and latch values and enables both pin groups. It then issues the reset write and at once tries a read and a write that must both be ignored. After the window closes, it confirms that the ignored write left no trace and that every earlier register reads zero.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam logic [7:0] A_ID     = 8'h00;
  localparam logic [7:0] A_FWHI   = 8'h01;
  localparam logic [7:0] A_FWLO   = 8'h02;
  localparam logic [7:0] A_STATE  = 8'h10;
  localparam logic [7:0] A_SYS    = 8'h40;
  localparam logic [7:0] A_DIR    = 8'h60;
  localparam logic [7:0] A_TYPE   = 8'h64;
  localparam logic [7:0] A_PULL   = 8'h68;
  localparam logic [7:0] A_SET    = 8'h6C;
  localparam logic [7:0] A_CLR    = 8'h70;
  localparam int         BANK_LEN = 3;

  localparam int SYS_EN_BIT  = 0;
  localparam int SYS_ALT_BIT = 3;
  localparam int SYS_RST_BIT = 7;

  // true when addr falls inside the three-byte bank starting at base
  function automatic logic in_bank(input logic [7:0] addr, input logic [7:0] base);
    return (addr >= base) && (addr < base + 8'(BANK_LEN));
  endfunction

  // byte index inside a bank
  function automatic logic [1:0] bank_idx(input logic [7:0] addr, input logic [7:0] base);
    logic [7:0] d;
    d = addr - base;
    return d[1:0];
  endfunction

  // identification: complement of the shifted seven-bit bus address
  function automatic logic [7:0] chip_id(input logic sel);
    return ~{6'b100001, sel, 1'b0};
  endfunction

  function automatic logic addr_mapped(input logic [7:0] addr);
    return (addr == A_ID) || (addr == A_FWHI) || (addr == A_FWLO) ||
           (addr == A_SYS) || in_bank(addr, A_STATE) || in_bank(addr, A_DIR) ||
           in_bank(addr, A_TYPE) || in_bank(addr, A_PULL) ||
           in_bank(addr, A_SET) || in_bank(addr, A_CLR);
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_boot.sv
module gpx_boot #(
  parameter int CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= LOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/gpx_pinmux.sv
module gpx_pinmux #(
  parameter int NUM_PINS  = 24,
  parameter int MAIN_PINS = 16
) (
  input  logic                gpio_en,
  input  logic                alt_en,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] typ,
  input  logic [NUM_PINS-1:0] pull,
  input  logic [NUM_PINS-1:0] olat,
  input  logic [NUM_PINS-1:0] sync_in,
  output logic [NUM_PINS-1:0] pin_en,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_pp,
  output logic [NUM_PINS-1:0] pin_pu,
  output logic [NUM_PINS-1:0] pin_pd,
  output logic [NUM_PINS-1:0] state
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i < MAIN_PINS) begin : g_main
      assign pin_en[i] = gpio_en;
    end else begin : g_alt
      assign pin_en[i] = gpio_en & alt_en;
    end
    logic drive, bias;
    assign drive      = pin_en[i] & dir[i];
    assign bias       = pin_en[i] & ~dir[i] & typ[i];
    assign pin_oe[i]  = drive;
    assign pin_out[i] = drive & olat[i];
    assign pin_pp[i]  = drive & typ[i];
    assign pin_pu[i]  = bias & pull[i];
    assign pin_pd[i]  = bias & ~pull[i];
    assign state[i]   = drive ? olat[i] : sync_in[i];
  end
endmodule

// File: rtl/gpx_regcore.sv
module gpx_regcore #(
  parameter int         NUM_PINS    = 24,
  parameter int         MAIN_PINS   = 16,
  parameter int         BOOT_CYCLES = 2000000,
  parameter logic [7:0] FW_HI       = 8'h01,
  parameter logic [7:0] FW_LO       = 8'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_sel,
  input  logic [7:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_pp,
  output logic [NUM_PINS-1:0] pin_pu,
  output logic [NUM_PINS-1:0] pin_pd
);
  import gpx_pkg::*;

  localparam int NBYTES = (NUM_PINS + 7) / 8;

  logic [NUM_PINS-1:0] dir_q, typ_q, pull_q, olat_q;
  logic                gpio_en_q, alt_en_q;
  logic [NUM_PINS-1:0] sync_in, state_w, pin_en_w;
  logic                busy_w, wr_ok, rd_ok, swrst_w, mapped_w;
  logic [7:0]          rd_mux;

  // named events for the checker
  assign wr_ok    = bus_wr & ~busy_w;
  assign rd_ok    = bus_rd & ~busy_w;
  assign swrst_w  = wr_ok && (bus_addr == A_SYS) && bus_wdata[SYS_RST_BIT];
  assign mapped_w = addr_mapped(bus_addr);

  gpx_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in)
  );

  gpx_boot #(.CYCLES(BOOT_CYCLES)) u_boot (
    .clk(clk), .rst_n(rst_n), .start(swrst_w), .busy(busy_w)
  );

  gpx_pinmux #(.NUM_PINS(NUM_PINS), .MAIN_PINS(MAIN_PINS)) u_pinmux (
    .gpio_en(gpio_en_q), .alt_en(alt_en_q),
    .dir(dir_q), .typ(typ_q), .pull(pull_q), .olat(olat_q),
    .sync_in(sync_in), .pin_en(pin_en_w),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pp(pin_pp),
    .pin_pu(pin_pu), .pin_pd(pin_pd), .state(state_w)
  );

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; typ_q <= '0; pull_q <= '0; olat_q <= '0;
      gpio_en_q <= 1'b0; alt_en_q <= 1'b0;
    end else if (swrst_w) begin
      dir_q <= '0; typ_q <= '0; pull_q <= '0; olat_q <= '0;
      gpio_en_q <= 1'b0; alt_en_q <= 1'b0;
    end else if (wr_ok) begin
      if (bus_addr == A_SYS) begin
        gpio_en_q <= bus_wdata[SYS_EN_BIT];
        alt_en_q  <= bus_wdata[SYS_ALT_BIT];
      end
      for (int k = 0; k < NBYTES; k++) begin
        for (int b = 0; b < 8; b++) begin
          if (8*k + b < NUM_PINS) begin
            if (bus_addr == A_DIR + 8'(k))  dir_q[8*k+b]  <= bus_wdata[b];
            if (bus_addr == A_TYPE + 8'(k)) typ_q[8*k+b]  <= bus_wdata[b];
            if (bus_addr == A_PULL + 8'(k)) pull_q[8*k+b] <= bus_wdata[b];
            if (bus_addr == A_SET + 8'(k) && bus_wdata[b]) olat_q[8*k+b] <= 1'b1;
            if (bus_addr == A_CLR + 8'(k) && bus_wdata[b]) olat_q[8*k+b] <= 1'b0;
          end
        end
      end
    end
  end

  // byte b of a pin vector, zero-padded past the last pin
  function automatic logic [7:0] pick(input logic [NUM_PINS-1:0] v, input logic [1:0] k);
    logic [8*NBYTES-1:0] wide;
    wide = '0;
    wide[NUM_PINS-1:0] = v;
    return wide[8*k +: 8];
  endfunction

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == A_ID)                rd_mux = chip_id(addr_sel);
    else if (bus_addr == A_FWHI)         rd_mux = FW_HI;
    else if (bus_addr == A_FWLO)         rd_mux = FW_LO;
    else if (bus_addr == A_SYS) begin
      rd_mux[SYS_EN_BIT]  = gpio_en_q;
      rd_mux[SYS_ALT_BIT] = alt_en_q;
    end
    else if (in_bank(bus_addr, A_STATE)) rd_mux = pick(state_w, bank_idx(bus_addr, A_STATE));
    else if (in_bank(bus_addr, A_DIR))   rd_mux = pick(dir_q, bank_idx(bus_addr, A_DIR));
    else if (in_bank(bus_addr, A_TYPE))  rd_mux = pick(typ_q, bank_idx(bus_addr, A_TYPE));
    else if (in_bank(bus_addr, A_PULL))  rd_mux = pick(pull_q, bank_idx(bus_addr, A_PULL));
    else if (in_bank(bus_addr, A_SET))   rd_mux = pick(olat_q, bank_idx(bus_addr, A_SET));
    else if (in_bank(bus_addr, A_CLR))   rd_mux = pick(olat_q, bank_idx(bus_addr, A_CLR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_ok ? rd_mux : 8'h00;
  end
endmodule

// File: rtl/gpx_regcore_chk.sv
module gpx_regcore_chk #(
  parameter int NUM_PINS  = 24,
  parameter int MAIN_PINS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                addr_sel,
  input logic [7:0]          bus_addr,
  input logic [7:0]          bus_wdata,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [7:0]          bus_rdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_pu,
  input logic [NUM_PINS-1:0] pin_pd,
  input logic [NUM_PINS-1:0] olat_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic                gpio_en_q,
  input logic                alt_en_q,
  input logic                busy_w,
  input logic                swrst_w,
  input logic                mapped_w
);
  import gpx_pkg::*;

  localparam int ALT_N = NUM_PINS - MAIN_PINS;

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !busy_w && bus_addr == A_ID) |=> bus_rdata == ~{6'b100001, $past(addr_sel), 1'b0}); // R2

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !busy_w && in_bank(bus_addr, A_SET)) |=> ((olat_q & $past(olat_q)) == $past(olat_q))); // R4

  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !busy_w && in_bank(bus_addr, A_CLR)) |=> ((olat_q | $past(olat_q)) == $past(olat_q))); // R5

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_pd) == '0); // R7

  AST_DRIVE_NO_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & (pin_pu | pin_pd)) == '0); // R7

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_en_q |-> (pin_oe == '0 && pin_pu == '0 && pin_pd == '0)); // R9

  AST_ALT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_en_q |-> (pin_oe[NUM_PINS-1 -: ALT_N] == '0 && pin_pu[NUM_PINS-1 -: ALT_N] == '0)); // R10

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_w |=> (busy_w && olat_q == '0 && dir_q == '0 && !gpio_en_q && !alt_en_q)); // R11

  AST_BUSY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && bus_rd) |=> bus_rdata == 8'h00); // R12

  AST_BUSY_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && bus_wr) |=> ($stable(dir_q) && $stable(olat_q) && $stable(gpio_en_q))); // R12

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped_w) |=> bus_rdata == 8'h00); // R13
endmodule

bind gpx_regcore gpx_regcore_chk #(.NUM_PINS(NUM_PINS), .MAIN_PINS(MAIN_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_pd(pin_pd), .olat_q(olat_q), .dir_q(dir_q),
  .gpio_en_q(gpio_en_q), .alt_en_q(alt_en_q), .busy_w(busy_w), .swrst_w(swrst_w),
  .mapped_w(mapped_w)
);

// File: tb/gpx_regcore_bench.sv
`timescale 1ns/1ps
module gpx_regcore_bench;
  localparam int BOOT = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_sel = 1'b0;
  logic [7:0]  bus_addr = 8'h00, bus_wdata = 8'h00;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_in = '0;
  logic [23:0] pin_out, pin_oe, pin_pp, pin_pu, pin_pd;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpx_regcore #(.BOOT_CYCLES(BOOT), .FW_HI(8'h03), .FW_LO(8'h2A)) u_gpx_regcore (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pp(pin_pp),
    .pin_pu(pin_pu), .pin_pd(pin_pd)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 oe", pin_oe, 24'h0);
    chk("R1 pu|pd|pp|out", pin_pu | pin_pd | pin_pp | pin_out, 24'h0);
    rd(8'h61, v); chk("R1 dir byte1", {16'h0, v}, 24'h0);
    rd(8'h6E, v); chk("R1 latch byte2", {16'h0, v}, 24'h0);
    rd(8'h00, v); chk("R2 id sel0", {16'h0, v}, 24'h7B);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    addr_sel = 1'b1;
    rd(8'h00, v); chk("R2 id sel1", {16'h0, v}, 24'h79);
    addr_sel = 1'b0;
    rd(8'h01, v); chk("R2 fw hi", {16'h0, v}, 24'h03);
    rd(8'h02, v); chk("R2 fw lo", {16'h0, v}, 24'h2A);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(8'h62, 8'h3C); wr(8'h64, 8'h96); wr(8'h6A, 8'h5A);
    rd(8'h62, v); chk("R3 dir byte2", {16'h0, v}, 24'h3C);
    rd(8'h64, v); chk("R3 type byte0", {16'h0, v}, 24'h96);
    rd(8'h6A, v); chk("R3 pull byte2", {16'h0, v}, 24'h5A);
    rd(8'h60, v); chk("R3 dir byte0 untouched", {16'h0, v}, 24'h00);
    wr(8'h62, 8'h00); wr(8'h64, 8'h00); wr(8'h6A, 8'h00);
  endtask

  task automatic t_setclr();
    logic [7:0] v;
    wr(8'h6C, 8'hA5); rd(8'h6C, v); chk("R4 set first", {16'h0, v}, 24'hA5);
    wr(8'h6C, 8'h0F); rd(8'h6C, v); chk("R4 set keeps others", {16'h0, v}, 24'hAF);
    wr(8'h70, 8'h81); rd(8'h70, v); chk("R5 clear", {16'h0, v}, 24'h2E);
    wr(8'h70, 8'h00); rd(8'h6C, v); chk("R5 clear zero no effect", {16'h0, v}, 24'h2E);
    wr(8'h6E, 8'hF0); rd(8'h72, v); chk("R4 set byte2 via clr bank", {16'h0, v}, 24'hF0);
  endtask

  task automatic t_output();
    logic [7:0] v;
    wr(8'h40, 8'h01);
    wr(8'h60, 8'hFF); wr(8'h64, 8'h0F);
    chk("R6 oe byte0", {16'h0, pin_oe[7:0]}, 24'hFF);
    chk("R6 out byte0", {16'h0, pin_out[7:0]}, 24'h2E);
    chk("R6 pp byte0", {16'h0, pin_pp[7:0]}, 24'h0F);
    pin_in[7:0] = 8'h55;
    repeat (3) @(negedge clk);
    rd(8'h10, v); chk("R8 state of driving pins", {16'h0, v}, 24'h2E);
  endtask

  task automatic t_input();
    logic [7:0] v;
    wr(8'h65, 8'hF0); wr(8'h69, 8'hCC);
    chk("R7 pu byte1", {16'h0, pin_pu[15:8]}, 24'hC0);
    chk("R7 pd byte1", {16'h0, pin_pd[15:8]}, 24'h30);
    chk("R7 oe byte1", {16'h0, pin_oe[15:8]}, 24'h00);
    pin_in[15:8] = 8'h5A;
    repeat (3) @(negedge clk);
    rd(8'h11, v); chk("R8 sync input", {16'h0, v}, 24'h5A);
    wr(8'h11, 8'hFF);
    rd(8'h11, v); chk("R8 state write ignored", {16'h0, v}, 24'h5A);
    chk("R8 state write no oe", {16'h0, pin_oe[15:8]}, 24'h00);
  endtask

  task automatic t_groups();
    logic [7:0] v;
    wr(8'h62, 8'hFF); wr(8'h66, 8'h0F); wr(8'h6A, 8'h0F);
    chk("R10 extra group gated", {16'h0, pin_oe[23:16]}, 24'h00);
    wr(8'h40, 8'h09);
    chk("R10 extra group on", {16'h0, pin_oe[23:16]}, 24'hFF);
    chk("R10 extra out", {16'h0, pin_out[23:16]}, 24'hF0);
    wr(8'h62, 8'h00);
    chk("R10 extra pulls", {8'h0, pin_pu[23:16], pin_pd[23:16]}, 24'h000F00);
    wr(8'h40, 8'h7F);
    rd(8'h40, v); chk("R9 sys readback", {16'h0, v}, 24'h09);
    wr(8'h40, 8'h08);
    chk("R9 disabled oe", pin_oe, 24'h0);
    chk("R9 disabled bias", pin_pu | pin_pd, 24'h0);
    wr(8'h40, 8'h09);
    chk("R9 reenabled", {16'h0, pin_oe[7:0]}, 24'hFF);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(8'h73, 8'hFF); wr(8'h63, 8'hFF); wr(8'h13, 8'hFF); wr(8'h41, 8'hFF);
    rd(8'h6C, v); chk("R13 latch untouched", {16'h0, v}, 24'h2E);
    chk("R13 oe untouched", pin_oe, 24'h0000FF);
    rd(8'h73, v); chk("R13 read 0x73", {16'h0, v}, 24'h00);
    rd(8'h63, v); chk("R13 read 0x63", {16'h0, v}, 24'h00);
    rd(8'h03, v); chk("R13 read 0x03", {16'h0, v}, 24'h00);
  endtask

  task automatic t_swrst();
    logic [7:0] v;
    wr(8'h40, 8'h89);
    chk("R11 outputs idle", pin_oe | pin_pu | pin_pd | pin_out, 24'h0);
    rd(8'h00, v); chk("R12 busy read", {16'h0, v}, 24'h00);
    wr(8'h60, 8'hFF);
    wr(8'h40, 8'h01);
    repeat (BOOT) @(negedge clk);
    rd(8'h60, v); chk("R12 busy write ignored", {16'h0, v}, 24'h00);
    rd(8'h40, v); chk("R11 sys cleared", {16'h0, v}, 24'h00);
    rd(8'h6C, v); chk("R11 latch cleared", {16'h0, v}, 24'h00);
    rd(8'h65, v); chk("R11 type cleared", {16'h0, v}, 24'h00);
    rd(8'h00, v); chk("R12 ready again", {16'h0, v}, 24'h7B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_regs();
    t_setclr();
    t_output();
    t_input();
    t_groups();
    t_unmapped();
    t_swrst();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule